// File: doc/BRIEF.md
# Modem Status and Loopback Controller

This block handles the modem handshake side of an asynchronous serial port. It brings four active-low modem inputs into the clock domain: clear-to-send, data-set-ready, ring indicator and carrier detect. It reports their asserted levels in an 8-bit status word, together with four change flags. The flags stay set until the status word is read. While its enable is on, a modem-status interrupt request is raised from the flags.

The block also holds a 6-bit control word. That word drives four active-low modem outputs, switches a diagnostic loopback and enables hardware flow control. In loopback the status levels come from the control bits instead of the pins, and the external outputs are parked inactive. The flow-control bits are decoded into separate enables for automatic RTS and automatic CTS handling. While flow control is on, a clear-to-send change does not interrupt.

Top module: `mdm_link_ctl`

## Requirements
- R1: After reset the control word reads 0x00, the status word reads 0x00 with all pins high, all four modem outputs are high, `stat_irq` is 0 and both automatic flow enables are 0.
- R2: Status bits [7:4] report the asserted (inverted) levels of cd, ri, dsr and cts, in that order from bit 7 down. A pin change becomes visible on the third rising clock edge after it is applied, not earlier.
- R3: Status bits 3, 1 and 0 (cd change, dsr change, cts change) set when the corresponding reported level changes in either direction.
- R4: Status bit 2 sets only when the ring indicator pin goes from low to high (reported level 1 to 0). Asserting the ring pin leaves it clear.
- R5: A cycle with `stat_rd` high returns the current status word and clears bits [3:0] at the next edge. A change that is detected at that same edge is kept.
- R6: `stat_irq` is high exactly when `stat_irq_en` is high and a change flag is set. It is 0 whenever `stat_irq_en` is low.
- R7: With control bit 5 (flow enable) set, a set cts change flag alone raises no interrupt, although the flag itself is still set. With bit 5 clear, the cts change flag does interrupt.
- R8: With control bit 4 (loopback) set, the reported levels follow the control bits: cd from bit 3, ri from bit 2, dsr from bit 0 and cts from bit 1. External pin changes are then ignored.
- R9: Outside loopback, `dtr_n_out`, `rts_n_out`, `aux1_n_out` and `aux2_n_out` are the inverses of control bits 0, 1, 2 and 3. In loopback all four are high.
- R10: With control bit 5 clear, both `auto_cts_en` and `auto_rts_en` are 0. With bit 5 set, `auto_cts_en` is 1 and `auto_rts_en` equals bit 1.
- R11: A write with `ctrl_wr` high loads `ctrl_wdata` at the next edge, and `ctrl_rdata` returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 6 | Control word write data |
| ctrl_rdata | output | 6 | Current control word |
| stat_rd | input | 1 | Status read strobe; clears change flags |
| stat_rdata | output | 8 | Status word: levels [7:4], change flags [3:0] |
| stat_irq_en | input | 1 | Modem-status interrupt enable |
| stat_irq | output | 1 | Modem-status interrupt request |
| cts_n_in | input | 1 | Clear-to-send pin, active low |
| dsr_n_in | input | 1 | Data-set-ready pin, active low |
| ri_n_in | input | 1 | Ring indicator pin, active low |
| cd_n_in | input | 1 | Carrier detect pin, active low |
| dtr_n_out | output | 1 | Data-terminal-ready output, active low |
| rts_n_out | output | 1 | Request-to-send output, active low |
| aux1_n_out | output | 1 | General output 1, active low |
| aux2_n_out | output | 1 | General output 2, active low |
| auto_rts_en | output | 1 | Automatic RTS handling enabled |
| auto_cts_en | output | 1 | Automatic CTS handling enabled |

## Verification
The status read that clears the flags and a fresh level change can land on the same clock edge. That edge is where the clear could wrongly destroy a new event. The bench first sets one change flag. It then applies a carrier-detect pin change and raises the read strobe two edges later, so the read coincides with the edge at which the synchronised level updates. It then expects the old flag gone and the new carrier-detect flag present.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

    localparam int CTRL_W = 6;
    localparam int LINE_W = 4;
    localparam int STAT_W = 2 * LINE_W;

    // Order matches status word bits [7:4] and [3:0]
    typedef struct packed {
        logic cd;
        logic ri;
        logic dsr;
        logic cts;
    } mdm_lines_t;

    typedef struct packed {
        logic flow;
        logic loop;
        logic aux2;
        logic aux1;
        logic rts;
        logic dtr;
    } mdm_ctrl_t;

endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
    parameter int   WIDTH   = 4,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);

    logic [STAGES-1:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = d_in;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= {(STAGES*WIDTH){RST_VAL}};
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign q_out = pipe_q[STAGES-1];

endmodule

// File: rtl/mdm_ctrl_reg.sv
module mdm_ctrl_reg
    import mdm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  mdm_ctrl_t  wdata,
    output mdm_ctrl_t  ctrl,
    output mdm_lines_t lb_lines,
    output logic       dtr_n,
    output logic       rts_n,
    output logic       aux1_n,
    output logic       aux2_n,
    output logic       auto_rts,
    output logic       auto_cts
);

    mdm_ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr) begin
            ctrl_d = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign ctrl = ctrl_q;

    // Loopback routing of control bits onto status levels
    always_comb begin
        lb_lines.cd  = ctrl_q.aux2;
        lb_lines.ri  = ctrl_q.aux1;
        lb_lines.dsr = ctrl_q.dtr;
        lb_lines.cts = ctrl_q.rts;
    end

    // Pins parked inactive (high) in loopback
    assign dtr_n  = ctrl_q.loop | ~ctrl_q.dtr;
    assign rts_n  = ctrl_q.loop | ~ctrl_q.rts;
    assign aux1_n = ctrl_q.loop | ~ctrl_q.aux1;
    assign aux2_n = ctrl_q.loop | ~ctrl_q.aux2;

    assign auto_cts = ctrl_q.flow;
    assign auto_rts = ctrl_q.flow & ctrl_q.rts;

    assert_loop_pins_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.loop |-> (dtr_n && rts_n && aux1_n && aux2_n));

    assert_auto_rts_needs_cts_R10: assert property (@(posedge clk) disable iff (!rst_n)
        auto_rts |-> auto_cts);

    assert_write_loads_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (ctrl_q == $past(wdata)));

endmodule

// File: rtl/mdm_status.sv
module mdm_status
    import mdm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  mdm_lines_t        ext_lines,
    input  mdm_lines_t        lb_lines,
    input  logic              loop_en,
    input  logic              flow_en,
    input  logic              rd,
    input  logic              irq_en,
    output logic [STAT_W-1:0] stat,
    output logic              irq
);

    typedef struct packed {
        mdm_lines_t lvl;
        mdm_lines_t chg;
    } stat_st_t;

    stat_st_t   st_d, st_q;
    mdm_lines_t evt;

    always_comb begin
        st_d.lvl = loop_en ? lb_lines : ext_lines;
        evt.cd   = st_q.lvl.cd  ^ st_d.lvl.cd;
        evt.dsr  = st_q.lvl.dsr ^ st_d.lvl.dsr;
        evt.cts  = st_q.lvl.cts ^ st_d.lvl.cts;
        evt.ri   = st_q.lvl.ri  & ~st_d.lvl.ri;
        // A read drops old flags; an event at the same edge survives
        st_d.chg = (rd ? '0 : st_q.chg) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat = st_q;
    assign irq  = irq_en & (st_q.chg.cd | st_q.chg.ri | st_q.chg.dsr
                          | (st_q.chg.cts & ~flow_en));

    assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && (st_d.lvl == st_q.lvl)) |=> (st_q.chg == '0));

    assert_flags_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> ((st_q.chg & $past(st_q.chg)) == $past(st_q.chg)));

    assert_ri_trailing_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.chg.ri) |-> ($past(st_q.lvl.ri) && !st_q.lvl.ri));

    assert_flow_masks_cts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_en && !st_q.chg.cd && !st_q.chg.ri && !st_q.chg.dsr) |-> !irq);

    assert_irq_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

endmodule

// File: rtl/mdm_link_ctl.sv
module mdm_link_ctl
    import mdm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [CTRL_W-1:0] ctrl_rdata,
    input  logic              stat_rd,
    output logic [STAT_W-1:0] stat_rdata,
    input  logic              stat_irq_en,
    output logic              stat_irq,
    input  logic              cts_n_in,
    input  logic              dsr_n_in,
    input  logic              ri_n_in,
    input  logic              cd_n_in,
    output logic              dtr_n_out,
    output logic              rts_n_out,
    output logic              aux1_n_out,
    output logic              aux2_n_out,
    output logic              auto_rts_en,
    output logic              auto_cts_en
);

    mdm_ctrl_t         ctrl;
    mdm_lines_t        lb_lines;
    mdm_lines_t        ext_lines;
    logic [LINE_W-1:0] pins_sync;

    mdm_sync #(
        .WIDTH   (LINE_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({cd_n_in, ri_n_in, dsr_n_in, cts_n_in}),
        .q_out (pins_sync)
    );

    assign ext_lines = mdm_lines_t'(~pins_sync);

    mdm_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (ctrl_wr),
        .wdata    (mdm_ctrl_t'(ctrl_wdata)),
        .ctrl     (ctrl),
        .lb_lines (lb_lines),
        .dtr_n    (dtr_n_out),
        .rts_n    (rts_n_out),
        .aux1_n   (aux1_n_out),
        .aux2_n   (aux2_n_out),
        .auto_rts (auto_rts_en),
        .auto_cts (auto_cts_en)
    );

    mdm_status u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_lines (ext_lines),
        .lb_lines  (lb_lines),
        .loop_en   (ctrl.loop),
        .flow_en   (ctrl.flow),
        .rd        (stat_rd),
        .irq_en    (stat_irq_en),
        .stat      (stat_rdata),
        .irq       (stat_irq)
    );

    assign ctrl_rdata = ctrl;

endmodule

// File: tb/mdm_link_ctl_tb_top.sv
module mdm_link_ctl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_wr = 1'b0;
    logic [5:0] ctrl_wdata = '0;
    logic [5:0] ctrl_rdata;
    logic       stat_rd = 1'b0;
    logic [7:0] stat_rdata;
    logic       stat_irq_en = 1'b0;
    logic       stat_irq;
    logic       cts_n_in = 1'b1, dsr_n_in = 1'b1, ri_n_in = 1'b1, cd_n_in = 1'b1;
    logic       dtr_n_out, rts_n_out, aux1_n_out, aux2_n_out;
    logic       auto_rts_en, auto_cts_en;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdm_link_ctl dut_i (
        .clk (clk), .rst_n (rst_n),
        .ctrl_wr (ctrl_wr), .ctrl_wdata (ctrl_wdata), .ctrl_rdata (ctrl_rdata),
        .stat_rd (stat_rd), .stat_rdata (stat_rdata),
        .stat_irq_en (stat_irq_en), .stat_irq (stat_irq),
        .cts_n_in (cts_n_in), .dsr_n_in (dsr_n_in), .ri_n_in (ri_n_in), .cd_n_in (cd_n_in),
        .dtr_n_out (dtr_n_out), .rts_n_out (rts_n_out),
        .aux1_n_out (aux1_n_out), .aux2_n_out (aux2_n_out),
        .auto_rts_en (auto_rts_en), .auto_cts_en (auto_cts_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_ctrl(input logic [5:0] v);
        ctrl_wr = 1'b1;
        ctrl_wdata = v;
        step(1);
        ctrl_wr = 1'b0;
    endtask

    task automatic read_clear();
        stat_rd = 1'b1;
        step(1);
        stat_rd = 1'b0;
    endtask

    function automatic logic [3:0] pins_out();
        return {aux2_n_out, aux1_n_out, rts_n_out, dtr_n_out};
    endfunction

    task automatic t_reset();
        check("R1 status", stat_rdata, 8'h00);
        check("R1 ctrl", ctrl_rdata, 6'h00);
        check("R1 pins", pins_out(), 4'hF);
        check("R1 irq", stat_irq, 1'b0);
        check("R1 auto", {auto_rts_en, auto_cts_en}, 2'b00);
    endtask

    task automatic t_levels();
        cts_n_in = 1'b0;
        dsr_n_in = 1'b0;
        step(2);
        check("R2 latency", stat_rdata, 8'h00);
        step(1);
        check("R2 R3 levels and change", stat_rdata, 8'h33);
        check("R6 irq disabled", stat_irq, 1'b0);
        stat_irq_en = 1'b1;
        #1;
        check("R6 irq enabled", stat_irq, 1'b1);
    endtask

    task automatic t_read();
        stat_rd = 1'b1;
        #1;
        check("R5 read value", stat_rdata, 8'h33);
        step(1);
        stat_rd = 1'b0;
        check("R5 cleared", stat_rdata, 8'h30);
        check("R6 irq drop", stat_irq, 1'b0);
    endtask

    task automatic t_ring();
        ri_n_in = 1'b0;
        step(3);
        check("R4 no leading flag", stat_rdata, 8'h70);
        check("R4 no irq", stat_irq, 1'b0);
        ri_n_in = 1'b1;
        step(3);
        check("R4 trailing flag", stat_rdata, 8'h34);
        check("R6 ring irq", stat_irq, 1'b1);
        read_clear();
    endtask

    task automatic t_same_edge();
        dsr_n_in = 1'b1;
        step(3);
        check("R3 dsr drop", stat_rdata, 8'h12);
        cd_n_in = 1'b0;
        step(2);
        stat_rd = 1'b1;
        step(1);
        stat_rd = 1'b0;
        check("R5 same-edge kept", stat_rdata, 8'h98);
        read_clear();
        check("R5 clear after", stat_rdata, 8'h90);
    endtask

    task automatic t_flow();
        write_ctrl(6'h20);
        check("R11 readback", ctrl_rdata, 6'h20);
        check("R10 cts only", {auto_rts_en, auto_cts_en}, 2'b01);
        write_ctrl(6'h22);
        check("R10 both", {auto_rts_en, auto_cts_en}, 2'b11);
        cts_n_in = 1'b1;
        step(3);
        check("R7 cts flag set", stat_rdata, 8'h81);
        check("R7 cts irq masked", stat_irq, 1'b0);
        dsr_n_in = 1'b0;
        step(3);
        check("R7 other irq", stat_irq, 1'b1);
        read_clear();
        write_ctrl(6'h00);
        check("R10 off", {auto_rts_en, auto_cts_en}, 2'b00);
        cts_n_in = 1'b0;
        step(3);
        check("R7 cts flag unmasked", stat_rdata, 8'hB1);
        check("R7 cts irq", stat_irq, 1'b1);
        read_clear();
    endtask

    task automatic t_outputs();
        write_ctrl(6'h0F);
        check("R11 readback", ctrl_rdata, 6'h0F);
        check("R9 pins active", pins_out(), 4'h0);
        write_ctrl(6'h05);
        check("R9 pins mix", pins_out(), 4'hA);
        step(1);
    endtask

    task automatic t_loop();
        // ext levels now cd=1 ri=0 dsr=1 cts=1
        write_ctrl(6'h15);
        check("R9 loop pins idle", pins_out(), 4'hF);
        step(1);
        check("R8 loop levels", stat_rdata, 8'h69);
        read_clear();
        cts_n_in = 1'b1;
        dsr_n_in = 1'b1;
        ri_n_in = 1'b0;
        cd_n_in = 1'b1;
        step(4);
        check("R8 pins ignored", stat_rdata, 8'h60);
        write_ctrl(6'h18);
        step(1);
        check("R8 R4 loop aux2", stat_rdata, 8'h8E);
        check("R9 loop pins still idle", pins_out(), 4'hF);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_levels();
        t_read();
        t_ring();
        t_same_edge();
        t_flow();
        t_outputs();
        t_loop();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule